// File: doc/BRIEF.md
# Debug Interrupt Request Aggregator

This block drives one interrupt line for each on-chip processor whenever a debug event is aimed at that processor. It merges two kinds of event. The first is a message-waiting strobe from the debug port, routed by the processor ID held in the current scan instruction. The second is an abort. An abort comes either from a debug-port abort strobe, which is broadcast to every processor, or from software writing ones into an abort command address.

Each processor has two pending flags, one for messages and one for aborts. The processor reads both through a small register bus. It clears the flags it has served by writing ones to them. A per-processor abort enable decides whether a pending abort reaches the interrupt line. A pending message always reaches it. The debug-port strobes arrive as single-cycle pulses on plain pins. The register bus has no handshake: a write takes effect at the clock edge where `bus_wr` is high, and read data follows `bus_addr` combinationally.

Top module: `dbg_irq_agg`

## Requirements
- R1: After reset, all message and abort pending flags are 0 and every `irq` bit is 0. The abort enable register reads as all ones (0x0F with four processors).
- R2: A cycle with `msg_evt` high sets the message pending flag of processor `msg_pid` and no other flag. That processor's `irq` is high from the following cycle.
- R3: While a processor's message flag is pending, further message events for it leave `irq` high without a drop. The flag stays set until it is cleared.
- R4: A cycle with `dbg_abort` high sets the abort pending flag of every processor.
- R5: A write to address 2 sets the abort pending flag of processor i for each bit i of `bus_wdata[3:0]` that is 1. Zero bits have no effect. Reading address 2 returns 0.
- R6: `irq[i]` equals message flag i OR (abort flag i AND enable bit i). A masked abort stays visible in the source register, and it raises `irq` as soon as its enable bit is set.
- R7: Address 0 is the source register. Bits [3:0] are the message flags and bits [7:4] are the abort flags. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: If a set event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R9: Address 1 is the abort enable register. Bits [3:0] are written and read back, and only a write to address 1 changes them. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| msg_evt | input | 1 | Single-cycle message-waiting strobe |
| msg_pid | input | 2 | Target processor ID from the loaded scan instruction |
| dbg_abort | input | 1 | Single-cycle debug-port abort strobe, broadcast |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 2 | Register address (0 source, 1 enable, 2 abort command) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| irq | output | 4 | Interrupt line per processor |

## Verification
The bench targets a clear write that lands in the same cycle as a set of the same flag. If the design gave priority to the clear, an event would be lost and the interrupt line would not rise. It repeats message events on a flag that is already pending. A design that toggled the flag or re-pulsed the line would show a low cycle on `irq`. It masks a pending abort and then unmasks it. The bench checks that the flag stays readable and that the line follows the enable bit. A design that gated the set path with the enable bit would leave the flag at zero. Writes with zero bits test that clear and abort-command writes touch no other flag.

// File: rtl/dbg_irq_pkg.sv
package dbg_irq_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_SRC   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_ABORT = 2'd2;
endpackage

// File: rtl/dbg_irq_route.sv
module dbg_irq_route #(
  parameter int NUM_PROC = 4,
  parameter int PID_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                msg_evt,
  input  logic [PID_W-1:0]    msg_pid,
  input  logic                dbg_abort,
  input  logic [NUM_PROC-1:0] sw_abt,
  output logic [NUM_PROC-1:0] msg_set,
  output logic [NUM_PROC-1:0] abt_set
);
  for (genvar i = 0; i < NUM_PROC; i++) begin : g_route
    assign msg_set[i] = msg_evt && (msg_pid == PID_W'(i));
    assign abt_set[i] = dbg_abort | sw_abt[i];
  end

  // R2: a message event targets exactly one processor
  p_msg_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_evt |-> (msg_set[msg_pid] && $onehot(msg_set)));
  p_msg_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_evt |-> (msg_set == '0));
  // R4: the debug-port abort reaches every processor
  p_abort_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_abort |-> (&abt_set));
endmodule

// File: rtl/dbg_irq_cell.sv
module dbg_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic msg_set,
  input  logic abt_set,
  input  logic msg_clr,
  input  logic abt_clr,
  input  logic abt_en,
  output logic msg_pend,
  output logic abt_pend,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_pend <= 1'b0;
      abt_pend <= 1'b0;
    end else begin
      msg_pend <= msg_set | (msg_pend & ~msg_clr);
      abt_pend <= abt_set | (abt_pend & ~abt_clr);
    end
  end

  assign irq = msg_pend | (abt_pend & abt_en);

  p_msg_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_set |=> msg_pend);
  p_msg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_pend && !msg_clr) |=> (msg_pend && irq));
  p_msg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_clr && !msg_set) |=> !msg_pend);
  p_abt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_clr && !abt_set) |=> !abt_pend);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_set && abt_clr) |=> abt_pend);
endmodule

// File: rtl/dbg_irq_regs.sv
module dbg_irq_regs
  import dbg_irq_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int SRC_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [SRC_W-1:0]    bus_wdata,
  input  logic [NUM_PROC-1:0] msg_pend,
  input  logic [NUM_PROC-1:0] abt_pend,
  output logic [NUM_PROC-1:0] abt_en,
  output logic [NUM_PROC-1:0] msg_clr,
  output logic [NUM_PROC-1:0] abt_clr,
  output logic [NUM_PROC-1:0] sw_abt,
  output logic [SRC_W-1:0]    bus_rdata
);
  logic wr_src, wr_en, wr_abort;

  assign wr_src   = bus_wr && (bus_addr == ADDR_SRC);
  assign wr_en    = bus_wr && (bus_addr == ADDR_EN);
  assign wr_abort = bus_wr && (bus_addr == ADDR_ABORT);

  assign msg_clr = wr_src   ? bus_wdata[NUM_PROC-1:0]        : '0;
  assign abt_clr = wr_src   ? bus_wdata[SRC_W-1:NUM_PROC]    : '0;
  assign sw_abt  = wr_abort ? bus_wdata[NUM_PROC-1:0]        : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abt_en <= '1;
    else if (wr_en) abt_en <= bus_wdata[NUM_PROC-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_SRC: bus_rdata = {abt_pend, msg_pend};
      ADDR_EN:  bus_rdata[NUM_PROC-1:0] = abt_en;
      default:  bus_rdata = '0;
    endcase
  end

  p_en_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (abt_en == $past(bus_wdata[NUM_PROC-1:0])));
  p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(abt_en));
endmodule

// File: rtl/dbg_irq_agg.sv
module dbg_irq_agg
  import dbg_irq_pkg::*;
#(
  parameter  int NUM_PROC = 4,
  localparam int PID_W    = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int SRC_W    = 2 * NUM_PROC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                msg_evt,
  input  logic [PID_W-1:0]    msg_pid,
  input  logic                dbg_abort,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [SRC_W-1:0]    bus_wdata,
  output logic [SRC_W-1:0]    bus_rdata,
  output logic [NUM_PROC-1:0] irq
);
  logic [NUM_PROC-1:0] msg_set, abt_set, msg_clr, abt_clr, sw_abt;
  logic [NUM_PROC-1:0] msg_pend, abt_pend, abt_en;

  dbg_irq_route #(.NUM_PROC(NUM_PROC), .PID_W(PID_W)) u_route (
    .clk(clk), .rst_n(rst_n), .msg_evt(msg_evt), .msg_pid(msg_pid),
    .dbg_abort(dbg_abort), .sw_abt(sw_abt),
    .msg_set(msg_set), .abt_set(abt_set)
  );

  for (genvar i = 0; i < NUM_PROC; i++) begin : g_cell
    dbg_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .msg_set(msg_set[i]), .abt_set(abt_set[i]),
      .msg_clr(msg_clr[i]), .abt_clr(abt_clr[i]),
      .abt_en(abt_en[i]),
      .msg_pend(msg_pend[i]), .abt_pend(abt_pend[i]), .irq(irq[i])
    );
  end

  dbg_irq_regs #(.NUM_PROC(NUM_PROC), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .msg_pend(msg_pend), .abt_pend(abt_pend),
    .abt_en(abt_en), .msg_clr(msg_clr), .abt_clr(abt_clr),
    .sw_abt(sw_abt), .bus_rdata(bus_rdata)
  );

  // R5: a software abort bit is visible as pending in the next cycle
  p_sw_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_abt != '0) |=> ((abt_pend & $past(sw_abt)) == $past(sw_abt)));
  // R6: no line is raised without a pending flag behind it
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(msg_pend | abt_pend)) == '0);
endmodule

// File: tb/dbg_irq_agg_tb.sv
module dbg_irq_agg_tb;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msg_evt = 1'b0;
  logic [1:0] msg_pid = '0;
  logic       dbg_abort = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] irq;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_msg = '0, m_abt = '0, m_en = 4'hF;

  always #5 clk = ~clk;

  dbg_irq_agg #(.NUM_PROC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .msg_evt(msg_evt), .msg_pid(msg_pid),
    .dbg_abort(dbg_abort), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [3:0] exp_irq();
    return m_msg | (m_abt & m_en);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic me, input logic [1:0] pid, input logic da,
                       input logic wr, input logic [1:0] a, input logic [7:0] wd);
    for (int i = 0; i < N; i++) begin
      logic sm, sa, cm, ca;
      sm = me && (pid == 2'(i));
      sa = da || (wr && a == 2'd2 && wd[i]);
      cm = wr && a == 2'd0 && wd[i];
      ca = wr && a == 2'd0 && wd[N+i];
      m_msg[i] = sm | (m_msg[i] & ~cm);
      m_abt[i] = sa | (m_abt[i] & ~ca);
    end
    if (wr && a == 2'd1) m_en = wd[3:0];
  endtask

  task automatic step(input logic me, input logic [1:0] pid, input logic da,
                      input logic wr, input logic [1:0] a, input logic [7:0] wd,
                      input string req);
    @(negedge clk);
    msg_evt = me; msg_pid = pid; dbg_abort = da;
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    model(me, pid, da, wr, a, wd);
    #1;
    msg_evt = 1'b0; dbg_abort = 1'b0; bus_wr = 1'b0;
    chk({4'h0, irq}, {4'h0, exp_irq()}, req);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #1 chk(bus_rdata, exp, req);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({4'h0, irq}, 8'h00, "R1 irq");
    rd(2'd0, 8'h00, "R1 source");
    rd(2'd1, 8'h0F, "R1 enable");
    rst_n = 1'b1;
    rd(2'd0, 8'h00, "R1 source after release");

    // R2 routing by pid
    step(1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 8'h00, "R2 irq");
    rd(2'd0, 8'h04, "R2 source");
    // R3 repeated events keep the line high
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 8'h00, "R3 irq held");
      chk({7'h0, irq[2]}, 8'h01, "R3 line");
    end
    // R7 clear with zero bits untouched, then real clear
    step(1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 8'hFB, "R7 zero bits keep");
    rd(2'd0, 8'h04, "R7 source kept");
    step(1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 8'h04, "R7 clear");
    rd(2'd0, 8'h00, "R7 source cleared");

    // R4 broadcast abort
    step(1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 8'h00, "R4 irq");
    rd(2'd0, 8'hF0, "R4 source");
    step(1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 8'hF0, "R7 abort clear");
    // R6 mask: abort pending but masked
    step(1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 8'h05, "R9 enable write");
    rd(2'd1, 8'h05, "R9 enable read");
    step(1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 8'h0A, "R6 masked abort");
    chk({4'h0, irq}, 8'h00, "R6 masked lines low");
    rd(2'd0, 8'hA0, "R5 source after sw abort");
    rd(2'd2, 8'h00, "R5 abort addr reads 0");
    rd(2'd3, 8'h00, "R9 addr3 reads 0");
    step(1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 8'h0F, "R6 unmask");
    chk({4'h0, irq}, 8'h0A, "R6 unmasked lines");
    // R8 set wins over clear
    step(1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 8'hFF, "R7 clear all");
    step(1'b1, 2'd1, 1'b1, 1'b1, 2'd0, 8'hF2, "R8 same-cycle");
    rd(2'd0, 8'hF2, "R8 source");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[3:2], (r[7:4] == 4'h0), r[8] & r[9], r[11:10],
           r[19:12], "R6 random irq");
      if (k % 8 == 0) begin
        rd(2'd0, {m_abt, m_msg}, "R7 random source");
        rd(2'd1, {4'h0, m_en}, "R9 random enable");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule